// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is an MDIO management master that software drives through a single 32-bit command and status word on a simple register bus. One write to that word launches exactly one frame on the MDC/MDIO pair. The word holds:

- the start flag,
- the frame type,
- the opcode,
- the PHY address,
- a register or device address,
- sixteen data bits.

While the frame is on the wire the start flag reads back as busy, and a ready bit reads as its complement. When a read frame finishes, the sixteen bits sampled from the PHY replace the low half of the word.

The engine serves both Clause 22 and Clause 45 management frames. Multi-frame Clause 45 accesses, such as an address frame followed by a read, are sequenced by software one word at a time. The MDC rate comes from the system clock through an internal divider. The block reset is synchronous. Pulsing it clears the data field, so a stale value from an earlier read is never mistaken for a fresh answer.

Top module: `mdio_cmd_engine`

## Requirements

The command word is laid out as follows:

| Bits | Field |
|------|-------|
| 31 | start/busy |
| 30 | ready |
| 29:25 | register address, or device address for Clause 45 |
| 24:20 | PHY address |
| 19:18 | opcode |
| 17:16 | frame type |
| 15:0 | data, or register address in a Clause 45 address frame |

- R1: Straight after reset, `regRdData` reads 0x4000_0000 (ready=1, everything else 0), and `mdc` and `mdioOe` are both low.
- R2: A write whose bit 31 is set, made while idle, sets busy (bit 31 = 1, bit 30 = 0) in the very next cycle. Busy stays set for exactly 128*HALF_DIV clock cycles. After that the word reads back {0, 1, fields as written}, except that a read frame replaces the data bits.
- R3: MDC runs only while busy. Each half period lasts HALF_DIV = CLK_HZ/(2*MDC_HZ) cycles (20 at the defaults: 100 MHz in, 2.5 MHz out). MDC is low when idle.
- R4: A frame is 64 bits, sent MSB first:
  - 32 preamble ones,
  - start (2 bits),
  - opcode (2 bits),
  - PHY address (5 bits),
  - register or device address (5 bits),
  - turnaround 10 on writes,
  - 16 data bits.

  The master changes MDIO only on the falling edge of MDC.
- R5: Frame type 1 gives a Clause 22 frame with start 01. The opcode goes onto the wire unchanged: 1 = write, 2 = read.
- R6: Any frame type other than 1 gives a Clause 45 frame with start 00. Opcode 0 = address frame (the data field is sent as the register address), 1 = write, 2 = post-read-increment, 3 = read.
- R7: Read frames are Clause 22 opcode 2 and Clause 45 opcodes 2 and 3. On a read frame, `mdioOe` drops from turnaround bit index 46 to the end of the frame. The 16 data bits are sampled on rising MDC edges and land in bits 15:0. With no responder, where MDIO is pulled high, the result is 0xFFFF.
- R8: A register write made while busy is ignored. It changes neither the frame on the wire nor any field of the word.
- R9: Pulsing the block reset after a read clears the captured data, so the word reads 0x4000_0000 again.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low block reset |
| regWrEn | input | 1 | Write strobe for the command word |
| regWrData | input | 32 | Command word being written |
| regRdData | output | 32 | Command and status word read back |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | Output enable for the MDIO pad |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification

Busy is visible in the first cycle after the accepting edge. It falls exactly 128*HALF_DIV edges later. The bench counts edges from the accepting edge and checks the count to the cycle. It also counts the samples taken while MDC is high, which should be 64*HALF_DIV. A responder model in the bench records MDIO and the output enable on every rising MDC edge. It places its data on MDIO after rising edges 48 to 63, which are exactly the edges at which the engine samples. All checks on the word are made at falling clock edges, once busy has cleared or after the reset pulse has ended, so each check sees a settled state.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_IDX     = PRE_BITS + 14;
  localparam int DATA_IDX   = TA_IDX + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [1:0] TYPE_C22   = 2'd1;
  localparam logic [1:0] OP_C22_RD  = 2'd2;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic done;
  } strobe_t;
endpackage

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    isRead,
  output strobe_t strb,
  output logic    busy,
  output logic    mdc,
  output logic    mdioOe
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);

  logic [CNT_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic tick, lastBit;

  assign tick    = busy && (divCnt == CNT_W'(HALF_DIV - 1));
  assign lastBit = (bitIdx == IDX_W'(FRAME_BITS - 1));

  always_comb begin
    strb.load   = startReq && !busy;
    strb.shift  = tick && mdc && !lastBit;
    strb.sample = tick && !mdc && isRead && (bitIdx >= IDX_W'(DATA_IDX));
    strb.done   = tick && mdc && lastBit;
  end

  assign mdioOe = busy && !(isRead && (bitIdx >= IDX_W'(TA_IDX)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (mdc) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(rstN)) |-> ($past(bitIdx) == IDX_W'(FRAME_BITS - 1)));
endmodule

// File: rtl/mdio_cmd_datapath.sv
module mdio_cmd_datapath
  import mdio_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic        cmdWr,
  input  logic        busy,
  input  logic [29:0] wrFields,
  input  logic        mdioIn,
  output logic [29:0] fields,
  output logic        isRead,
  output logic        mdioOut
);
  logic [4:0]  regAddr, phyAddr;
  logic [1:0]  opCode, frameType;
  logic [15:0] dataWord, rdShift;
  logic [FRAME_BITS-1:0] shiftReg;

  logic [4:0]  wRegAddr, wPhyAddr;
  logic [1:0]  wOp, wType, wStart;
  logic [15:0] wData;

  assign {wRegAddr, wPhyAddr, wOp, wType, wData} = wrFields;
  assign wStart = (wType == TYPE_C22) ? 2'b01 : 2'b00;

  assign isRead  = (frameType == TYPE_C22) ? (opCode == OP_C22_RD) : opCode[1];
  assign fields  = {regAddr, phyAddr, opCode, frameType, dataWord};
  assign mdioOut = shiftReg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddr   <= '0;
      phyAddr   <= '0;
      opCode    <= '0;
      frameType <= '0;
      dataWord  <= '0;
      rdShift   <= '0;
      shiftReg  <= '0;
    end else begin
      if (strb.load) begin
        regAddr   <= wRegAddr;
        phyAddr   <= wPhyAddr;
        opCode    <= wOp;
        frameType <= wType;
        dataWord  <= wData;
        shiftReg  <= {{PRE_BITS{1'b1}}, wStart, wOp, wPhyAddr, wRegAddr, 2'b10, wData};
      end else if (strb.shift) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.sample) rdShift <= {rdShift[14:0], mdioIn};
      if (strb.done && isRead) dataWord <= rdShift;
    end
  end

  // R8
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWr && !strb.done) |=> $stable(fields));

  // R7
  sample_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> (isRead && busy));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int MDC_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int HALF_DIV = CLK_HZ / (2 * MDC_HZ);

  strobe_t     strb;
  logic        busy, isRead;
  logic [29:0] fields;
  logic        unusedRdyBit;

  assign unusedRdyBit = regWrData[30];

  mdio_cmd_ctrl #(.HALF_DIV(HALF_DIV)) uCtrl (
    .clk(clk), .rstN(rstN),
    .startReq(regWrEn && regWrData[31]),
    .isRead(isRead), .strb(strb), .busy(busy),
    .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_cmd_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWr(regWrEn), .busy(busy),
    .wrFields(regWrData[29:0]), .mdioIn(mdioIn),
    .fields(fields), .isRead(isRead), .mdioOut(mdioOut)
  );

  assign regRdData = {busy, ~busy, fields};

  // R4
  mdio_fall_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy && !$stable(mdioOut)) |-> $fell(mdc));
endmodule

// File: tb/tb_mdio_cmd_engine.sv
module tb_mdio_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 100_000_000;
  localparam int MDC_HZ     = 2_500_000;
  localparam int HALF       = CLK_HZ / (2 * MDC_HZ);

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, mdc, mdioOut, mdioOe, mdioIn;
  logic [31:0] regWrData = '0, regRdData;

  int tests = 0, fails = 0, edgeCnt = 0, cycles = 0, highCnt = 0;
  bit rspOn = 0;
  logic [15:0] rspData = '0;
  logic [63:0] frameCap = '0, oeCap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_cmd_engine #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  assign mdioIn = (rspOn && edgeCnt >= 48 && edgeCnt < 64) ? rspData[63 - edgeCnt] : 1'b1;

  always @(posedge mdc) begin
    frameCap <= {frameCap[62:0], mdioOut};
    oeCap    <= {oeCap[62:0], mdioOe};
    edgeCnt  <= edgeCnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [4:0] ra, input logic [4:0] pa,
                                      input logic [1:0] op, input logic [1:0] ty,
                                      input logic [15:0] d);
    return {1'b1, 1'b0, ra, pa, op, ty, d};
  endfunction

  function automatic logic [63:0] frameOf(input logic [31:0] w);
    return {32'hFFFF_FFFF, (w[17:16] == 2'd1) ? 2'b01 : 2'b00, w[19:18], w[24:20], w[29:25], 2'b10, w[15:0]};
  endfunction

  task automatic runCmd(input logic [31:0] w, input bit rsp, input logic [15:0] rd,
                        input bit midWr, input logic [31:0] w2);
    rspOn = rsp; rspData = rd; edgeCnt = 0;
    @(negedge clk); regWrEn = 1'b1; regWrData = w;
    @(negedge clk); regWrEn = 1'b0;
    check(regRdData[31:30] == 2'b10, "R2 busy set after launch", 64'(regRdData[31:30]), 64'h2);
    cycles = 0; highCnt = 0;
    while (regRdData[31] && cycles < 6000) begin
      regWrEn = (midWr && cycles == 100);
      regWrData = w2;
      @(negedge clk);
      regWrEn = 1'b0;
      cycles++;
      if (mdc) highCnt++;
    end
  endtask

  task automatic testReset();
    check(regRdData == 32'h4000_0000, "R1 reset word", 64'(regRdData), 64'h4000_0000);
    check({mdc, mdioOe} == 2'b00, "R1 mdc/oe idle", 64'({mdc, mdioOe}), 64'h0);
  endtask

  task automatic testC22Write();
    logic [31:0] w = cmd(5'h04, 5'h03, 2'd1, 2'd1, 16'hA5C3);
    runCmd(w, 0, '0, 0, '0);
    check(cycles == 128*HALF, "R2 busy length", 64'(cycles), 64'(128*HALF));
    check(highCnt == 64*HALF, "R3 mdc high time", 64'(highCnt), 64'(64*HALF));
    check(frameCap == frameOf(w), "R4 R5 c22 write frame", frameCap, frameOf(w));
    check(oeCap == '1, "R4 oe whole write frame", oeCap, '1);
    check(regRdData == {2'b01, w[29:0]}, "R2 word after write", 64'(regRdData), 64'({2'b01, w[29:0]}));
    check({mdc, mdioOe} == 2'b00, "R3 idle after frame", 64'({mdc, mdioOe}), 64'h0);
  endtask

  task automatic testRead(input logic [31:0] w, input bit rsp, input logic [15:0] rd, input string tag);
    logic [15:0] expD = rsp ? rd : 16'hFFFF;
    logic [63:0] expF = frameOf(w);
    runCmd(w, rsp, rd, 0, '0);
    check(frameCap[63:18] == expF[63:18], {tag, " header"}, 64'(frameCap[63:18]), 64'(expF[63:18]));
    check(oeCap == {{46{1'b1}}, 18'h0}, "R7 release from turnaround", oeCap, {{46{1'b1}}, 18'h0});
    check(regRdData[15:0] == expD, {tag, " R7 read data"}, 64'(regRdData[15:0]), 64'(expD));
    check(regRdData[29:16] == w[29:16], {tag, " fields kept"}, 64'(regRdData[29:16]), 64'(w[29:16]));
  endtask

  task automatic testC45Write(input logic [31:0] w, input string tag);
    runCmd(w, 0, '0, 0, '0);
    check(frameCap == frameOf(w), tag, frameCap, frameOf(w));
  endtask

  task automatic testBusyIgnore();
    logic [31:0] w  = cmd(5'h0A, 5'h11, 2'd1, 2'd1, 16'h3C3C);
    logic [31:0] w2 = cmd(5'h15, 5'h0E, 2'd2, 2'd0, 16'hFFFF);
    runCmd(w, 0, '0, 1, w2);
    check(frameCap == frameOf(w), "R8 frame unchanged", frameCap, frameOf(w));
    check(regRdData == {2'b01, w[29:0]}, "R8 word unchanged", 64'(regRdData), 64'({2'b01, w[29:0]}));
    check(cycles == 128*HALF, "R8 no restart", 64'(cycles), 64'(128*HALF));
  endtask

  task automatic testResetClears();
    testRead(cmd(5'h02, 5'h07, 2'd2, 2'd1, 16'h0000), 1, 16'h7500, "R9 pre-read");
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regRdData == 32'h4000_0000, "R9 data cleared by reset", 64'(regRdData), 64'h4000_0000);
  endtask

  initial begin
    repeat (200_000 - 10) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testC22Write();
    testRead(cmd(5'h02, 5'h01, 2'd2, 2'd1, 16'h0000), 1, 16'hBEEF, "R5 c22 read");
    testRead(cmd(5'h03, 5'h1F, 2'd2, 2'd1, 16'h0000), 0, 16'h0000, "R7 no responder");
    testC45Write(cmd(5'h1E, 5'h09, 2'd0, 2'd0, 16'h1234), "R6 c45 address frame");
    testC45Write(cmd(5'h01, 5'h09, 2'd1, 2'd0, 16'h5A5A), "R6 c45 write frame");
    testRead(cmd(5'h07, 5'h12, 2'd3, 2'd0, 16'h0000), 1, 16'h0F0F, "R6 c45 read");
    testRead(cmd(5'h07, 5'h12, 2'd2, 2'd0, 16'h0000), 1, 16'h8001, "R6 c45 post-read-inc");
    testBusyIgnore();
    testResetClears();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule